// File: doc/BRIEF.md
# Monochrome Tile Grayscale Expander

This block turns one monochrome tile of 8 by 8 pixels into the byte stream that a 16-level grayscale display controller stores as 4 bits per pixel. The tile arrives on a 64-bit parallel input with a valid/ready handshake. Byte k of that word, bits `8k+7` down to `8k`, is column k of the tile. Bit i of each column byte is the pixel in row i.

Once a tile is taken, the block sends 32 bytes on a byte stream with valid, ready and last. Each row produces four bytes. Every pixel becomes one nibble: `0xF` when the pixel is set, `0x0` when it is clear. Within each row the column pairs are placed in a swapped order that the controller's memory layout needs.

An all-zero tile is flagged when it is captured and takes a shortcut that forces zero bytes. Its output must match the normal path exactly.

Top module: `tile_gray_expander`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A tile is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `out_valid` is 1 and `in_ready` is 0.
- R3: A set pixel gives nibble `0xF` and a clear pixel gives nibble `0x0`.
- R4: Output byte number n (counting from 0 to 31) belongs to row n/4, which is bit n/4 of every column byte. Rows go out from 0 to 7.
- R5: In a row's group, position g = n mod 4 carries two columns. g=0 carries columns 2 (low nibble, bits 3:0) and 3 (high nibble, bits 7:4). g=1 carries columns 0 and 1, g=2 carries columns 6 and 7, and g=3 carries columns 4 and 5.
- R6: An all-zero input tile yields 32 bytes of `0x00`, including when the previous tile was non-zero.
- R7: `out_last` is 1 only with the 32nd byte (n=31) while `out_valid` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values into the next cycle.
- R9: `in_valid` and `in_tile` have no effect while a tile is being emitted. The stream still carries the tile that was accepted.
- R10: In the cycle after the 32nd byte is taken, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Tile offered |
| in_ready | output | 1 | Block can take a tile |
| in_tile | input | 64 | Tile, byte k = column k, bit i = row i |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Two expanded pixels |
| out_last | output | 1 | Marks the 32nd byte |

## Verification
The bench builds the block with its default 8 by 8 tile, which gives 32 bytes per tile. With that size, every group position, every row and the wrap of the byte index after the last byte are all exercised.

The bench covers three downstream ready patterns: always ready, ready every other cycle, and ready two cycles in three. These patterns bring holds on the first byte, on middle bytes and on the last byte within reach.

Tiles are sent back to back. One of them is all zero and follows a non-zero tile, which tests the zero shortcut against the normal path. While a tile is being emitted, the bench offers a different tile to show that the input is ignored.

// File: rtl/tge_pkg.sv
// Package: shared constants, state type and the pixel-level expansion
// used by the tile grayscale expander. Assumes two pixels per output byte.
package tge_pkg;

    localparam int unsigned PIX_BITS  = 4;
    localparam int unsigned BYTE_BITS = 2 * PIX_BITS;

    typedef enum logic {
        ST_LOAD,
        ST_EMIT
    } tge_state_e;

    // Turn one monochrome pixel into a full-on or full-off gray level.
    function automatic logic [PIX_BITS-1:0] gray_of(input logic pix);
        return pix ? {PIX_BITS{1'b1}} : {PIX_BITS{1'b0}};
    endfunction

endpackage

// File: rtl/tge_seq.sv
// Sequencer: takes a tile when idle, then counts out ROWS*COLS/2 bytes.
// It splits the count into a row number and a group position.
// Assumes ROWS and COLS/2 are powers of two.
module tge_seq
    import tge_pkg::*;
#(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    localparam int unsigned BPR   = COLS / 2,
    localparam int unsigned TOTAL = ROWS * BPR,
    localparam int unsigned IDX_W = $clog2(TOTAL),
    localparam int unsigned SEL_W = $clog2(BPR),
    localparam int unsigned ROW_W = IDX_W - SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             load,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic [ROW_W-1:0] row_sel,
    output logic [SEL_W-1:0] grp_sel
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    tge_state_e       state_q;
    logic [IDX_W-1:0] idx_q;

    // Move between idle and emitting, and step the byte index on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
        end else if (state_q == ST_LOAD) begin
            if (in_valid) begin
                state_q <= ST_EMIT;
                idx_q   <= '0;
            end
        end else if (out_ready) begin
            if (idx_q == LAST_IDX) begin
                state_q <= ST_LOAD;
            end
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Decode handshake outputs and index fields from the state.
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        out_valid = (state_q == ST_EMIT);
        load      = in_ready && in_valid;
        out_last  = out_valid && (idx_q == LAST_IDX);
        row_sel   = idx_q[IDX_W-1:SEL_W];
        grp_sel   = idx_q[SEL_W-1:0];
    end

endmodule

// File: rtl/tge_store.sv
// Tile store: holds the accepted tile and a flag that marks it all-zero.
// Assumes load is only raised while the sequencer is idle.
module tge_store #(
    parameter int unsigned TILE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TILE_W-1:0] tile_in,
    output logic [TILE_W-1:0] tile_q,
    output logic              blank_q
);

    // Capture the tile and its all-zero flag on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_q  <= '0;
            blank_q <= 1'b1;
        end else if (load) begin
            tile_q  <= tile_in;
            blank_q <= (tile_in == '0);
        end
    end

endmodule

// File: rtl/tge_pack.sv
// Pack: forms one output byte from the stored tile.
// It picks the swapped column pair for the group position and expands both pixels.
// Assumes column-major input and power-of-two ROWS and COLS.
module tge_pack
    import tge_pkg::*;
#(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned SEL_W = COL_W - 1
) (
    input  logic [COLS*ROWS-1:0] tile_q,
    input  logic                 blank_q,
    input  logic [ROW_W-1:0]     row_sel,
    input  logic [SEL_W-1:0]     grp_sel,
    output logic [BYTE_BITS-1:0] byte_o
);

    logic [ROWS*COLS-1:0] by_row;
    logic [COLS-1:0]      cur_row;
    logic [SEL_W-1:0]     pair;
    logic                 lo_pix;
    logic                 hi_pix;

    // Transpose column-major storage into row-major order.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign by_row[r*COLS+c] = tile_q[c*ROWS+r];
        end
    end

    // Select the row, swap neighbouring pairs and expand both pixels.
    always_comb begin
        cur_row = by_row[{row_sel, {COL_W{1'b0}}} +: COLS];
        pair    = grp_sel ^ SEL_W'(1);
        lo_pix  = cur_row[{pair, 1'b0}];
        hi_pix  = cur_row[{pair, 1'b1}];
        byte_o  = blank_q ? '0 : {gray_of(hi_pix), gray_of(lo_pix)};
    end

endmodule

// File: rtl/tile_gray_expander.sv
// Top: takes a monochrome tile over valid/ready and streams its
// 4-bit-per-pixel bytes with valid/ready/last.
// Assumes COLS/2 and ROWS are powers of two.
module tile_gray_expander
    import tge_pkg::*;
#(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 8,
    localparam int unsigned TILE_W = ROWS * COLS,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned SEL_W  = $clog2(COLS) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [TILE_W-1:0]    in_tile,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [BYTE_BITS-1:0] out_data,
    output logic                 out_last
);

    logic              load;
    logic [ROW_W-1:0]  row_sel;
    logic [SEL_W-1:0]  grp_sel;
    logic [TILE_W-1:0] tile_q;
    logic              blank_q;

    tge_seq #(.ROWS(ROWS), .COLS(COLS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .load      (load),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .row_sel   (row_sel),
        .grp_sel   (grp_sel)
    );

    tge_store #(.TILE_W(TILE_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tile_in (in_tile),
        .tile_q  (tile_q),
        .blank_q (blank_q)
    );

    tge_pack #(.ROWS(ROWS), .COLS(COLS)) pack_i (
        .tile_q  (tile_q),
        .blank_q (blank_q),
        .row_sel (row_sel),
        .grp_sel (grp_sel),
        .byte_o  (out_data)
    );

endmodule

// File: rtl/tge_chk.sv
// Checker: port-level protocol properties of the tile grayscale expander.
// Attached through bind; all properties are off while reset is low.
module tge_chk #(
    parameter int unsigned TILE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [TILE_W-1:0] in_tile,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last
);

    // R2
    accept_to_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R6
    zero_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_tile == '0) |=> (out_data == 8'h00));

    // R7
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R8
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R10
    reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

endmodule

bind tile_gray_expander tge_chk #(.TILE_W(ROWS * COLS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tile   (in_tile),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tile_gray_expander_tb_top.sv
// Directed bench for the tile grayscale expander.
module tile_gray_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_tile = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tile_gray_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_tile   (in_tile),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected byte n for a tile, from the column table of R4/R5 and the levels of R3.
    function automatic logic [7:0] exp_byte(input logic [63:0] t, input int n);
        int r = n / 4;
        int lo;
        case (n % 4)
            0: lo = 2;
            1: lo = 0;
            2: lo = 6;
            default: lo = 4;
        endcase
        return {t[(lo+1)*8+r] ? 4'hF : 4'h0, t[lo*8+r] ? 4'hF : 4'h0};
    endfunction

    function automatic bit rdy_pat(input int mode, input int g);
        if (mode == 0) return 1'b1;
        if (mode == 1) return g[0];
        return (g % 3) != 0;
    endfunction

    // Offer a tile and check it is taken with the R2 handshake.
    task automatic push(input logic [63:0] t);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_tile  = t;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid && !in_ready, "R2 accept", {62'd0, out_valid, in_ready}, 64'h2);
    endtask

    // Collect 32 bytes and check data (R3,R4,R5), last (R7), holds (R8), junk input (R9) and reopen (R10).
    task automatic drain(input logic [63:0] t, input int mode, input bit junk, input string tag);
        int k = 0;
        int g = 0;
        bit was_stall = 1'b0;
        logic [7:0] held = '0;
        logic held_last = 1'b0;
        while (k < 32) begin
            out_ready = rdy_pat(mode, g);
            if (junk) begin
                in_valid = 1'b1;
                in_tile  = ~t ^ 64'h5A5A_0F0F_3C3C_9696;
            end
            #1;
            chk(out_valid, {tag, " R2 valid"}, 64'(out_valid), 64'h1);
            if (was_stall)
                chk(out_data == held && out_last == held_last, {tag, " R8 hold"},
                    {55'd0, out_last, out_data}, {55'd0, held_last, held});
            if (out_ready) begin
                chk(out_data == exp_byte(t, k), {tag, junk ? " R9 data" : " R3 R4 R5 data"},
                    64'(out_data), 64'(exp_byte(t, k)));
                chk(out_last == (k == 31), {tag, " R7 last"}, 64'(out_last), 64'(k == 31));
                k++;
                was_stall = 1'b0;
            end else begin
                held = out_data;
                held_last = out_last;
                was_stall = 1'b1;
            end
            @(negedge clk);
            g++;
        end
        out_ready = 1'b0;
        in_valid  = 1'b0;
        #1;
        chk(in_ready && !out_valid, {tag, " R10 reopen"}, {62'd0, in_ready, out_valid}, 64'h2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(in_ready && !out_valid && !out_last, "R1 reset", {61'd0, in_ready, out_valid, out_last}, 64'h4);
    endtask

    task automatic t_single_pixel();
        push(64'h0000_0000_0000_0001);
        drain(64'h0000_0000_0000_0001, 0, 1'b0, "single");
        push(64'h8000_0000_0000_0000);
        drain(64'h8000_0000_0000_0000, 0, 1'b0, "corner");
    endtask

    task automatic t_patterns();
        push(64'h0123_4567_89AB_CDEF);
        drain(64'h0123_4567_89AB_CDEF, 0, 1'b0, "mixed");
        push(64'h8040_2010_0804_0201);
        drain(64'h8040_2010_0804_0201, 0, 1'b0, "diag");
        push(64'hFFFF_FFFF_FFFF_FFFF);
        drain(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0, "full");
    endtask

    task automatic t_zero();
        push(64'h00FF_00FF_00FF_00FF);
        drain(64'h00FF_00FF_00FF_00FF, 0, 1'b0, "stripe");
        push(64'h0);
        drain(64'h0, 2, 1'b0, "R6 zero");
    endtask

    task automatic t_backpressure();
        push(64'hA55A_C33C_0FF0_9669);
        drain(64'hA55A_C33C_0FF0_9669, 1, 1'b0, "stall-alt");
        push(64'h1357_9BDF_2468_ACE0);
        drain(64'h1357_9BDF_2468_ACE0, 2, 1'b0, "stall-3");
    endtask

    task automatic t_busy_ignore();
        push(64'hDEAD_BEEF_0BAD_F00D);
        drain(64'hDEAD_BEEF_0BAD_F00D, 2, 1'b1, "busy");
    endtask

    initial begin
        t_reset();
        t_single_pixel();
        t_patterns();
        t_zero();
        t_backpressure();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule